// File: doc/BRIEF.md
# OUT Endpoint Receive Transfer Controller

This block runs one device-side OUT endpoint transfer. Host data packets arrive as a byte stream with a last-byte marker. Each packet is written into a receive FIFO that holds whole packets only. A packet that does not fit is thrown away in full and answered with a refusal. The block keeps two budgets for the transfer: the number of packets still allowed and the number of bytes still to be read by the application. It raises a sticky receive interrupt each time a packet is committed. It also sets its own NAK flag once the packet budget is spent or a short packet ends the transfer.

The application starts a transfer with a one-cycle enable strobe that loads both budgets. It then drains bytes through a valid/ready read port. When the byte budget reaches zero through reads, the transfer-complete interrupt is raised. Completion therefore follows the application's reads, not the arrival of the last packet.

The receive stream never applies back-pressure: `rx_ready` is held high. Overflow is resolved by dropping the whole packet instead of stalling the sender. The read port follows the usual rules. A byte moves when `rd_valid` and `rd_ready` are both high, and while `rd_ready` is low the presented byte does not change. `DEPTH` must be a power of two no smaller than `MPS`. Every packet carries at least one byte.

Top module: `oep_rx_ctrl`

## Requirements
- R1: A packet is stored only if all of its bytes fit in the FIFO. A packet that overflows is dropped whole: `rx_nak` pulses, `rx_ack` stays low, none of its bytes ever become readable, and the overflow alone does not set `nak`.
- R2: `rx_ack` pulses for one cycle, and `irq_rxlvl` is set, in the cycle after the edge that takes a packet's last byte. While the packet's earlier bytes arrive, `rd_valid` and `irq_rxlvl` do not change.
- R3: The packet that brings `pkt_left` to zero sets `nak`. While `nak` is high, every new packet is refused with an `rx_nak` pulse and leaves the FIFO contents unchanged.
- R4: An accepted packet shorter than `MPS` bytes sets `nak`, even when `pkt_left` is still above zero.
- R5: Each byte popped on the read port lowers `bytes_left` by one, saturating at zero. `irq_xfrc` is set in the cycle after the pop that takes `bytes_left` from one to zero, and not before.
- R6: `pkt_left` falls by one for each accepted packet. Refused packets leave it unchanged.
- R7: An `ep_enable` strobe loads `pkt_left` from `cfg_pkts` and `bytes_left` from `cfg_bytes`, and clears `irq_xfrc`. It clears `nak` if `cfg_pkts` is non-zero and sets it if `cfg_pkts` is zero.
- R8: `irq_rxlvl` and `irq_xfrc` stay set until a one-cycle `clr_rxlvl` or `clr_xfrc` strobe clears them.
- R9: Bytes leave the read port in arrival order. `rd_data` holds steady while `rd_valid` is high and `rd_ready` is low. `rd_valid` falls once all committed bytes are read.
- R10: After reset, `nak` is 1, `pkt_left` and `bytes_left` are 0, `rd_valid`, `rx_ack`, `rx_nak` and both interrupts are 0, and `rx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Receive byte present |
| rx_ready | output | 1 | Receive side ready, held high |
| rx_data | input | DW | Receive byte |
| rx_last | input | 1 | Marks a packet's final byte |
| rx_ack | output | 1 | Pulse: packet accepted |
| rx_nak | output | 1 | Pulse: packet refused |
| rd_valid | output | 1 | Committed byte available |
| rd_ready | input | 1 | Application takes the byte |
| rd_data | output | DW | Byte at the FIFO head |
| ep_enable | input | 1 | Strobe: start a transfer |
| cfg_pkts | input | PCW | Packet budget to load |
| cfg_bytes | input | BCW | Byte budget to load |
| nak | output | 1 | Endpoint refusing packets |
| pkt_left | output | PCW | Packets still allowed |
| bytes_left | output | BCW | Bytes still to be read |
| irq_rxlvl | output | 1 | Sticky: a packet was committed |
| irq_xfrc | output | 1 | Sticky: transfer complete |
| clr_rxlvl | input | 1 | Write-one-to-clear for irq_rxlvl |
| clr_xfrc | input | 1 | Write-one-to-clear for irq_xfrc |

## Verification
The bench sweeps every packet length from one byte up to the maximum. A design that ignored short packets would leave `nak` low after 1 to 7 bytes. A design that counted bytes at arrival would raise completion before any byte is read. Overflow is driven both from a full FIFO and from a partly filled one, where the first bytes fit and the rest do not. A design without rollback would then leak a stale partial packet onto the read port. Further runs cover packet budgets of one and two followed by an extra packet, which catches an off-by-one in the budget, and a held read port, which catches data that moves without a handshake.

// File: rtl/oep_pkg.sv
package oep_pkg;
  // Outcome of one received packet, reported the cycle after its last byte
  typedef enum logic [1:0] {
    PKT_IDLE = 2'd0,
    PKT_ACK  = 2'd1,
    PKT_NAK  = 2'd2
  } pkt_res_e;
endpackage

// File: rtl/oep_rx_fifo.sv
// Byte FIFO with a tentative write pointer: a packet's bytes become visible
// only on commit, and a rollback discards them.
module oep_rx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          commit,
  input  logic          rollback,
  input  logic          rd_en,
  output logic          full,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_tmp, wr_cmt, rd_ptr;
  logic [PW-1:0] fill_tmp;

  assign fill_tmp = wr_tmp - rd_ptr;
  assign full     = (fill_tmp == PW'(DEPTH));
  assign rd_valid = (wr_cmt != rd_ptr);
  assign rd_data  = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_tmp[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_tmp <= '0;
      wr_cmt <= '0;
      rd_ptr <= '0;
    end else begin
      if (rollback)   wr_tmp <= wr_cmt;
      else if (wr_en) wr_tmp <= wr_tmp + 1'b1;
      if (commit)     wr_cmt <= wr_tmp + PW'(wr_en);
      if (rd_en)      rd_ptr <= rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/oep_rx_admit.sv
// Per-packet admission: decides at each byte whether the packet survives,
// and at the last byte commits or rolls it back.
module oep_rx_admit
  import oep_pkg::*;
#(
  parameter int MPS = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     beat,
  input  logic     last,
  input  logic     nak,
  input  logic     full,
  output logic     wr_en,
  output logic     commit,
  output logic     rollback,
  output logic     short_pkt,
  output pkt_res_e res
);
  localparam int LW = $clog2(MPS + 1);

  logic          in_pkt_q, drop_q;
  logic [LW-1:0] len_q, len_base, len_nx;
  logic          drop_eff;

  // A refusal is decided by the NAK flag at the first byte, or by running out of room
  assign drop_eff  = (in_pkt_q ? drop_q : nak) | full;
  assign len_base  = in_pkt_q ? len_q : '0;
  assign len_nx    = (len_base >= LW'(MPS)) ? LW'(MPS) : len_base + 1'b1;
  assign short_pkt = (len_nx < LW'(MPS));

  assign wr_en    = beat & ~drop_eff;
  assign commit   = beat & last & ~drop_eff;
  assign rollback = beat & last & drop_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0;
      drop_q   <= 1'b0;
      len_q    <= '0;
      res      <= PKT_IDLE;
    end else begin
      if (beat) begin
        in_pkt_q <= ~last;
        drop_q   <= drop_eff;
        len_q    <= len_nx;
      end
      if (beat && last) res <= drop_eff ? PKT_NAK : PKT_ACK;
      else              res <= PKT_IDLE;
    end
  end
endmodule

// File: rtl/oep_ep_state.sv
// Transfer budgets, the NAK flag and the sticky interrupt flags.
module oep_ep_state #(
  parameter int PCW = 4,
  parameter int BCW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ep_enable,
  input  logic [PCW-1:0] cfg_pkts,
  input  logic [BCW-1:0] cfg_bytes,
  input  logic           commit,
  input  logic           short_pkt,
  input  logic           pop,
  input  logic           clr_rxlvl,
  input  logic           clr_xfrc,
  output logic           nak,
  output logic [PCW-1:0] pkt_left,
  output logic [BCW-1:0] bytes_left,
  output logic           irq_rxlvl,
  output logic           irq_xfrc
);
  // Packet budget and NAK
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_left <= '0;
      nak      <= 1'b1;
    end else if (ep_enable) begin
      pkt_left <= cfg_pkts;
      nak      <= (cfg_pkts == '0);
    end else if (commit) begin
      if (pkt_left != '0) pkt_left <= pkt_left - 1'b1;
      if (pkt_left <= PCW'(1) || short_pkt) nak <= 1'b1;
    end
  end

  // Byte budget and completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytes_left <= '0;
      irq_xfrc   <= 1'b0;
    end else begin
      if (clr_xfrc) irq_xfrc <= 1'b0;
      if (ep_enable) begin
        bytes_left <= cfg_bytes;
        irq_xfrc   <= 1'b0;
      end else if (pop && bytes_left != '0) begin
        bytes_left <= bytes_left - 1'b1;
        if (bytes_left == BCW'(1)) irq_xfrc <= 1'b1;
      end
    end
  end

  // Receive interrupt: a new commit wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq_rxlvl <= 1'b0;
    else if (commit)    irq_rxlvl <= 1'b1;
    else if (clr_rxlvl) irq_rxlvl <= 1'b0;
  end
endmodule

// File: rtl/oep_rx_ctrl.sv
module oep_rx_ctrl
  import oep_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int MPS   = 8,
  parameter int PCW   = 4,
  parameter int BCW   = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rx_valid,
  output logic           rx_ready,
  input  logic [DW-1:0]  rx_data,
  input  logic           rx_last,
  output logic           rx_ack,
  output logic           rx_nak,
  output logic           rd_valid,
  input  logic           rd_ready,
  output logic [DW-1:0]  rd_data,
  input  logic           ep_enable,
  input  logic [PCW-1:0] cfg_pkts,
  input  logic [BCW-1:0] cfg_bytes,
  output logic           nak,
  output logic [PCW-1:0] pkt_left,
  output logic [BCW-1:0] bytes_left,
  output logic           irq_rxlvl,
  output logic           irq_xfrc,
  input  logic           clr_rxlvl,
  input  logic           clr_xfrc
);
  logic     beat, wr_en, commit, rollback, short_pkt, full, pop;
  pkt_res_e res;

  assign rx_ready = 1'b1;
  assign beat     = rx_valid & rx_ready;
  assign pop      = rd_valid & rd_ready;
  assign rx_ack   = (res == PKT_ACK);
  assign rx_nak   = (res == PKT_NAK);

  oep_rx_admit #(.MPS(MPS)) u_admit (
    .clk(clk), .rst_n(rst_n), .beat(beat), .last(rx_last), .nak(nak),
    .full(full), .wr_en(wr_en), .commit(commit), .rollback(rollback),
    .short_pkt(short_pkt), .res(res)
  );

  oep_rx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(rx_data),
    .commit(commit), .rollback(rollback), .rd_en(pop), .full(full),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  oep_ep_state #(.PCW(PCW), .BCW(BCW)) u_state (
    .clk(clk), .rst_n(rst_n), .ep_enable(ep_enable), .cfg_pkts(cfg_pkts),
    .cfg_bytes(cfg_bytes), .commit(commit), .short_pkt(short_pkt), .pop(pop),
    .clr_rxlvl(clr_rxlvl), .clr_xfrc(clr_xfrc), .nak(nak),
    .pkt_left(pkt_left), .bytes_left(bytes_left), .irq_rxlvl(irq_rxlvl),
    .irq_xfrc(irq_xfrc)
  );
endmodule

// File: rtl/oep_rx_ctrl_chk.sv
module oep_rx_ctrl_chk #(
  parameter int DW  = 8,
  parameter int PCW = 4,
  parameter int BCW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rx_valid,
  input logic           rx_last,
  input logic           rx_ack,
  input logic           rx_nak,
  input logic           rd_valid,
  input logic           rd_ready,
  input logic [DW-1:0]  rd_data,
  input logic           ep_enable,
  input logic           nak,
  input logic [PCW-1:0] pkt_left,
  input logic [BCW-1:0] bytes_left,
  input logic           irq_rxlvl,
  input logic           irq_xfrc,
  input logic           clr_rxlvl,
  input logic           clr_xfrc
);
  a_r1_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ack |-> !rx_nak);

  a_r2_ack_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ack |-> $past(rx_valid && rx_last));

  a_r2_irq_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_rxlvl) |-> rx_ack);

  a_r3_budget_nak: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ack && pkt_left == '0) |-> nak);

  a_r6_pkt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ack && !$past(ep_enable)) |-> (pkt_left == $past(pkt_left) - PCW'(1)));

  a_r5_done_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_xfrc) |-> (bytes_left == '0 && $past(rd_valid && rd_ready)));

  a_r8_rxlvl_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rxlvl && !clr_rxlvl) |=> irq_rxlvl);

  a_r8_xfrc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_xfrc && !clr_xfrc && !ep_enable) |=> irq_xfrc);

  a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

bind oep_rx_ctrl oep_rx_ctrl_chk #(.DW(DW), .PCW(PCW), .BCW(BCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_last(rx_last),
  .rx_ack(rx_ack), .rx_nak(rx_nak), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .ep_enable(ep_enable), .nak(nak), .pkt_left(pkt_left),
  .bytes_left(bytes_left), .irq_rxlvl(irq_rxlvl), .irq_xfrc(irq_xfrc),
  .clr_rxlvl(clr_rxlvl), .clr_xfrc(clr_xfrc)
);

// File: tb/test_oep_rx_ctrl.sv
module test_oep_rx_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8, DEPTH = 16, MPS = 8, PCW = 4, BCW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_last = 1'b0, rd_ready = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic ep_enable = 1'b0, clr_rxlvl = 1'b0, clr_xfrc = 1'b0;
  logic [PCW-1:0] cfg_pkts = '0;
  logic [BCW-1:0] cfg_bytes = '0;
  logic rx_ready, rx_ack, rx_nak, rd_valid, nak, irq_rxlvl, irq_xfrc;
  logic [DW-1:0] rd_data;
  logic [PCW-1:0] pkt_left;
  logic [BCW-1:0] bytes_left;

  int checks = 0, fails = 0;
  int q[256];
  int qh = 0, qt = 0;
  int exp_bl = 0, exp_xfrc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oep_rx_ctrl #(.DW(DW), .DEPTH(DEPTH), .MPS(MPS), .PCW(PCW), .BCW(BCW)) i_oep_rx_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_last(rx_last), .rx_ack(rx_ack), .rx_nak(rx_nak),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .ep_enable(ep_enable), .cfg_pkts(cfg_pkts), .cfg_bytes(cfg_bytes),
    .nak(nak), .pkt_left(pkt_left), .bytes_left(bytes_left),
    .irq_rxlvl(irq_rxlvl), .irq_xfrc(irq_xfrc), .clr_rxlvl(clr_rxlvl),
    .clr_xfrc(clr_xfrc)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic enable(input int p, input int b);
    @(negedge clk);
    ep_enable = 1'b1; cfg_pkts = PCW'(p); cfg_bytes = BCW'(b);
    @(negedge clk);
    ep_enable = 1'b0;
    exp_bl = b; exp_xfrc = 0;
  endtask

  task automatic clear_irqs();
    @(negedge clk);
    clr_rxlvl = 1'b1; clr_xfrc = 1'b1;
    @(negedge clk);
    clr_rxlvl = 1'b0; clr_xfrc = 1'b0;
    exp_xfrc = 0;
  endtask

  // Sends len bytes base, base+1, ...; res: 1 accepted, 2 refused, 0 none
  task automatic send_pkt(input int len, input int base, output int res);
    logic v0, i0;
    v0 = rd_valid; i0 = irq_rxlvl;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk("R2 rd_valid mid-packet", int'(rd_valid), int'(v0));
        chk("R2 irq_rxlvl mid-packet", int'(irq_rxlvl), int'(i0));
      end
      rx_valid = 1'b1; rx_data = DW'(base + i); rx_last = (i == len - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
    chk("R1 ack and nak exclusive", int'(rx_ack && rx_nak), 0);
    res = rx_ack ? 1 : (rx_nak ? 2 : 0);
  endtask

  task automatic push_model(input int len, input int base);
    for (int i = 0; i < len; i++) begin
      q[qt % 256] = (base + i) % 256;
      qt++;
    end
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R9 rd_valid while data held", int'(rd_valid), 1);
      chk("R9 read order", int'(rd_data), q[qh % 256]);
      chk("R5 bytes_left before pop", int'(bytes_left), exp_bl);
      chk("R5 irq_xfrc before pop", int'(irq_xfrc), exp_xfrc);
      qh++;
      rd_ready = 1'b1;
      if (exp_bl > 0) begin
        if (exp_bl == 1) exp_xfrc = 1;
        exp_bl--;
      end
    end
    @(negedge clk);
    rd_ready = 1'b0;
    chk("R5 bytes_left after drain", int'(bytes_left), exp_bl);
    chk("R5 irq_xfrc after drain", int'(irq_xfrc), exp_xfrc);
    chk("R9 rd_valid after drain", int'(rd_valid), int'(qh != qt));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all): actual hung expected done, actual %0d expected %0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int res;
    logic [DW-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 nak", int'(nak), 1);
    chk("R10 pkt_left", int'(pkt_left), 0);
    chk("R10 bytes_left", int'(bytes_left), 0);
    chk("R10 rd_valid", int'(rd_valid), 0);
    chk("R10 irq_rxlvl", int'(irq_rxlvl), 0);
    chk("R10 irq_xfrc", int'(irq_xfrc), 0);
    chk("R10 rx_ack/rx_nak", int'(rx_ack) + int'(rx_nak), 0);
    chk("R10 rx_ready", int'(rx_ready), 1);

    // R3: refused before any enable, nothing stored
    send_pkt(4, 8'h40, res);
    chk("R3 refused while nak", res, 2);
    chk("R3 nothing stored", int'(rd_valid), 0);

    // Length sweep: R2, R4, R5, R6, R8, R9
    for (int len = 1; len <= MPS; len++) begin
      enable(3, len);
      clear_irqs();
      chk("R7 nak cleared by enable", int'(nak), 0);
      send_pkt(len, 16 * len, res);
      chk("R2 packet accepted", res, 1);
      push_model(len, 16 * len);
      @(negedge clk);
      chk("R2 irq_rxlvl set", int'(irq_rxlvl), 1);
      chk("R2 ack is one cycle", int'(rx_ack), 0);
      chk("R6 pkt_left", int'(pkt_left), 2);
      chk("R4 short packet nak", int'(nak), int'(len < MPS));
      drain(len);
      chk("R8 irq_rxlvl still set", int'(irq_rxlvl), 1);
      clear_irqs();
      chk("R8 irq_rxlvl cleared", int'(irq_rxlvl), 0);
      chk("R8 irq_xfrc cleared", int'(irq_xfrc), 0);
    end

    // Budget sweep: R3, R6
    for (int p = 1; p <= 2; p++) begin
      enable(p, MPS * p);
      for (int k = 0; k < p; k++) begin
        send_pkt(MPS, 100 + 10 * k, res);
        chk("R6 full packet accepted", res, 1);
        push_model(MPS, 100 + 10 * k);
        chk("R6 pkt_left after packet", int'(pkt_left), p - k - 1);
        chk("R3 nak after budget", int'(nak), int'(k == p - 1));
      end
      send_pkt(MPS, 200, res);
      chk("R3 extra packet refused", res, 2);
      chk("R6 pkt_left unchanged by refusal", int'(pkt_left), 0);
      drain(MPS * p);
    end

    // Overflow: R1
    enable(3, 2 * MPS);
    send_pkt(MPS, 1, res);  push_model(MPS, 1);
    send_pkt(MPS, 9, res);  push_model(MPS, 9);
    chk("R1 two packets fill FIFO", res, 1);
    send_pkt(MPS, 60, res);
    chk("R1 overflow refused (full)", res, 2);
    chk("R1 overflow leaves nak low", int'(nak), 0);
    chk("R6 pkt_left after overflow", int'(pkt_left), 1);
    drain(4);
    send_pkt(MPS, 70, res);
    chk("R1 overflow refused (partial fit)", res, 2);
    drain(8);
    send_pkt(MPS, 80, res); push_model(MPS, 80);
    chk("R1 packet fits after drain", res, 1);
    chk("R3 nak after last budgeted packet", int'(nak), 1);
    drain(4 + MPS);

    // Back-pressure on the read port: R9
    enable(1, 3);
    send_pkt(3, 33, res); push_model(3, 33);
    @(negedge clk);
    held = rd_data;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R9 data held under back-pressure", int'(rd_data), int'(held));
      chk("R9 valid held under back-pressure", int'(rd_valid), 1);
    end
    drain(3);

    // R7: enable with zero budget, then a real budget
    enable(0, 0);
    chk("R7 zero budget sets nak", int'(nak), 1);
    chk("R7 enable clears irq_xfrc", int'(irq_xfrc), 0);
    send_pkt(2, 5, res);
    chk("R7 zero budget refuses", res, 2);
    enable(2, 5);
    chk("R7 nak cleared", int'(nak), 0);
    chk("R7 pkt_left loaded", int'(pkt_left), 2);
    chk("R7 bytes_left loaded", int'(bytes_left), 5);

    summary();
    $finish;
  end
endmodule